// File: doc/BRIEF.md
# SPI Receive Status and Interrupt Logic

This block sits beside the serial shift engine of an SPI peripheral and owns the receive side of its register view. Bytes completed by the shift engine arrive with a one-cycle strobe and are kept in a four-entry FIFO. Software drains the FIFO through a read strobe and reads a 16-bit status word that carries the FIFO occupancy, a live excess-occupancy indication and five sticky event flags. The event flags are read-to-clear.

The event flags cover four conditions. An overflow flag sets when a byte arrives at a full FIFO. A receive flag sets when the configured byte count has been collected in interrupt-driven mode. A chip-select error flag sets when select is released while a byte is only partly shifted. Two framing flags record the falling and the rising edge of chip-select during continuous master transfers. A single interrupt request is the OR of the set flags. The overflow contribution is masked while a flush is held.

Top module: `spi_rx_status`

## Requirements
- R1: Status bits [10:8] give FIFO occupancy from 0 to 4. A byte with `rx_valid_i` high is appended, `fifo_rd_i` removes the oldest, `rx_data_o` shows the oldest byte, and bytes leave in arrival order.
- R2: Status bit 7 (overflow) sets one cycle after a byte arrives while occupancy is 4 with no pop in the same cycle. That byte is discarded.
- R3: Status bits 14, 13, 12, 7 and 6 clear on the cycle after `sta_rd_i`. A flag whose event happens in the same cycle as the read stays set.
- R4: `cs_n_i` is active-low. Its falling edge sets bit 13 and its rising edge sets bit 14, but only when `cfg_master_i`, `cfg_cont_i` and `cfg_cs_irq_en_i` are all high in the edge cycle.
- R5: Bit 12 (select error) sets when `cs_n_i` rises while `byte_partial_i` is high, whatever the mode.
- R6: Bit 11 is combinational and non-sticky. It equals 1 exactly when occupancy is greater than `cfg_thresh_i`.
- R7: Bit 6 (receive) sets when an accepted byte brings occupancy to `cfg_thresh_i`+1 while `cfg_tim_i` and `cfg_dma_i` are both 0. It never sets while `cfg_dma_i` is 1.
- R8: Bit 15 always reads 0, and after reset the whole status word is 0.
- R9: `irq_o` is the OR of bits 14, 13, 12 and 6, together with bit 7 masked by `cfg_flush_i`.
- R10: While `cfg_flush_i` is high, occupancy is 0 from the next cycle on and arriving bytes are dropped without setting overflow.
- R11: With the FIFO empty, `rx_data_o` is 0 and a pop leaves occupancy at 0. A push and a pop in the same cycle on a full FIFO keep 4 bytes and do not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_byte_i | input | 8 | Byte completed by the shift engine |
| rx_valid_i | input | 1 | One-cycle strobe for rx_byte_i |
| byte_partial_i | input | 1 | Shift engine holds a partly shifted byte |
| cs_n_i | input | 1 | Chip-select line, active low |
| cfg_thresh_i | input | 2 | Byte-count threshold field |
| cfg_flush_i | input | 1 | Flush receive FIFO |
| cfg_tim_i | input | 1 | Transfer-initiate mode (1: transmit-driven) |
| cfg_dma_i | input | 1 | DMA mode enable |
| cfg_cont_i | input | 1 | Continuous transfer mode |
| cfg_master_i | input | 1 | Master mode |
| cfg_cs_irq_en_i | input | 1 | Chip-select edge interrupt enable |
| sta_rd_i | input | 1 | Status word read strobe |
| fifo_rd_i | input | 1 | FIFO data read strobe |
| sta_o | output | 16 | Status word |
| rx_data_o | output | 8 | Oldest FIFO byte, 0 when empty |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A status read can fall in the same cycle as a new flag event, and a FIFO pop can fall in the same cycle as a push at full occupancy. The bench provokes the first by pulsing `sta_rd_i` on the cycle a chip-select edge or a counted byte arrives, with another flag already set. The second it provokes by pushing and popping together at four bytes. In random traffic both collisions happen often. A bench model built from the requirements judges each one: a coincident event must survive the read while older flags clear, and the full push-pop pair must keep occupancy at 4 with the overflow bit clear.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned STA_W   = 16;
  localparam int unsigned POS_CSR = 14;
  localparam int unsigned POS_CSF = 13;
  localparam int unsigned POS_CSE = 12;
  localparam int unsigned POS_XS  = 11;
  localparam int unsigned POS_LVL = 8;
  localparam int unsigned POS_OVF = 7;
  localparam int unsigned POS_RX  = 6;

  typedef enum int unsigned {
    FLG_RX  = 0,
    FLG_OVF = 1,
    FLG_CSE = 2,
    FLG_CSF = 3,
    FLG_CSR = 4
  } flag_e;
  localparam int unsigned NUM_FLG = 5;

  typedef struct packed {
    logic [1:0] thresh;
    logic       flush;
    logic       tim;
    logic       dma;
    logic       cont;
    logic       master;
    logic       cs_irq_en;
  } rx_cfg_t;
endpackage

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] level_nx_o,
  output logic          push_ok_o,
  output logic          overflow_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          full, empty, pop_ok, push_ok;

  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);

  assign pop_ok  = pop_i && !empty && !flush_i;
  assign push_ok = push_i && !flush_i && (!full || pop_ok);

  // full + concurrent pop frees a slot, so no overflow
  assign overflow_o = push_i && !flush_i && full && !pop_ok;
  assign push_ok_o  = push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    if (flush_i) level_nx_o = '0;
    else level_nx_o = level_q + LW'(push_ok) - LW'(pop_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      level_q <= level_nx_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = empty ? '0 : mem_q[rd_ptr_q];
  assign level_o = level_q;
endmodule

// File: rtl/spi_rx_cs_mon.sv
module spi_rx_cs_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic partial_i,
  input  logic edge_en_i,
  output logic fall_o,
  output logic rise_o,
  output logic err_o
);
  logic cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_n_q <= 1'b1;
    else         cs_n_q <= cs_n_i;
  end

  assign fall_o = edge_en_i &&  cs_n_q && !cs_n_i;
  assign rise_o = edge_en_i && !cs_n_q &&  cs_n_i;
  // released mid-byte
  assign err_o  = !cs_n_q && cs_n_i && partial_i;
endmodule

// File: rtl/spi_rx_flag_bank.sv
module spi_rx_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= ev_i[g] | (flag_q & ~clr_i);
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rx_valid_i,
  input  logic          byte_partial_i,
  input  logic          cs_n_i,
  input  logic [1:0]    cfg_thresh_i,
  input  logic          cfg_flush_i,
  input  logic          cfg_tim_i,
  input  logic          cfg_dma_i,
  input  logic          cfg_cont_i,
  input  logic          cfg_master_i,
  input  logic          cfg_cs_irq_en_i,
  input  logic          sta_rd_i,
  input  logic          fifo_rd_i,
  output logic [15:0]   sta_o,
  output logic [DW-1:0] rx_data_o,
  output logic          irq_o
);
  rx_cfg_t cfg;
  assign cfg = '{thresh: cfg_thresh_i, flush: cfg_flush_i, tim: cfg_tim_i,
                 dma: cfg_dma_i, cont: cfg_cont_i, master: cfg_master_i,
                 cs_irq_en: cfg_cs_irq_en_i};

  logic [LW-1:0]      level, level_nx, rx_target;
  logic               push_ok, ovf_ev;
  logic               cs_fall, cs_rise, cs_err;
  logic [NUM_FLG-1:0] ev, flags;

  spi_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (cfg.flush),
    .push_i     (rx_valid_i),
    .wdata_i    (rx_byte_i),
    .pop_i      (fifo_rd_i),
    .rdata_o    (rx_data_o),
    .level_o    (level),
    .level_nx_o (level_nx),
    .push_ok_o  (push_ok),
    .overflow_o (ovf_ev)
  );

  spi_rx_cs_mon u_cs_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_n_i),
    .partial_i (byte_partial_i),
    .edge_en_i (cfg.master && cfg.cont && cfg.cs_irq_en),
    .fall_o    (cs_fall),
    .rise_o    (cs_rise),
    .err_o     (cs_err)
  );

  assign rx_target = LW'(cfg.thresh) + LW'(1);

  always_comb begin
    ev          = '0;
    ev[FLG_RX]  = push_ok && !cfg.tim && !cfg.dma && (level_nx == rx_target);
    ev[FLG_OVF] = ovf_ev;
    ev[FLG_CSE] = cs_err;
    ev[FLG_CSF] = cs_fall;
    ev[FLG_CSR] = cs_rise;
  end

  spi_rx_flag_bank #(.N(NUM_FLG)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .clr_i   (sta_rd_i),
    .flags_o (flags)
  );

  always_comb begin
    sta_o              = '0;
    sta_o[POS_CSR]     = flags[FLG_CSR];
    sta_o[POS_CSF]     = flags[FLG_CSF];
    sta_o[POS_CSE]     = flags[FLG_CSE];
    sta_o[POS_XS]      = level > LW'(cfg.thresh);
    sta_o[POS_LVL+:3]  = 3'(level);
    sta_o[POS_OVF]     = flags[FLG_OVF];
    sta_o[POS_RX]      = flags[FLG_RX];
  end

  assign irq_o = flags[FLG_CSR] | flags[FLG_CSF] | flags[FLG_CSE] | flags[FLG_RX]
               | (flags[FLG_OVF] & ~cfg.flush);
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic        fifo_rd_i,
  input logic        sta_rd_i,
  input logic [1:0]  cfg_thresh_i,
  input logic        cfg_flush_i,
  input logic        cfg_dma_i,
  input logic        cfg_cont_i,
  input logic        cfg_master_i,
  input logic        cfg_cs_irq_en_i,
  input logic [15:0] sta_o,
  input logic [7:0]  rx_data_o,
  input logic        irq_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta_o[15] == 1'b0); // R8
  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta_o[10:8] <= 3'd4); // R1
  AST_OVF_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !cfg_flush_i && !fifo_rd_i && sta_o[10:8] == 3'd4) |=> sta_o[7]); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sta_o[13] && !sta_rd_i) |=> sta_o[13]); // R3
  AST_CS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cfg_master_i && cfg_cont_i && cfg_cs_irq_en_i) && !sta_o[13]) |=> !sta_o[13]); // R4
  AST_XS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta_o[11] == (sta_o[10:8] > {1'b0, cfg_thresh_i})); // R6
  AST_RX_DMA_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dma_i && !sta_o[6]) |=> !sta_o[6]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sta_o[14:12] == 3'b0 && !sta_o[6] && (!sta_o[7] || cfg_flush_i)) |-> !irq_o); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_flush_i |=> sta_o[10:8] == 3'd0); // R10
  AST_EMPTY_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sta_o[10:8] == 3'd0) |-> rx_data_o == 8'h00); // R11
endmodule

bind spi_rx_status spi_rx_status_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rx_valid_i      (rx_valid_i),
  .fifo_rd_i       (fifo_rd_i),
  .sta_rd_i        (sta_rd_i),
  .cfg_thresh_i    (cfg_thresh_i),
  .cfg_flush_i     (cfg_flush_i),
  .cfg_dma_i       (cfg_dma_i),
  .cfg_cont_i      (cfg_cont_i),
  .cfg_master_i    (cfg_master_i),
  .cfg_cs_irq_en_i (cfg_cs_irq_en_i),
  .sta_o           (sta_o),
  .rx_data_o       (rx_data_o),
  .irq_o           (irq_o)
);

// File: tb/spi_rx_status_bench.sv
module spi_rx_status_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rxb = '0;
  logic       valid = 0, partial = 0, cs_n = 1;
  logic [1:0] thresh = '0;
  logic       flush = 0, tim = 0, dma = 0, cont = 0, master = 0, csen = 0;
  logic       sta_rd = 0, fifo_rd = 0;
  logic [15:0] sta;
  logic [7:0]  rdata;
  logic        irq;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_q [4];
  int         m_cnt;
  logic       m_ovf, m_rx, m_cse, m_csf, m_csr, m_cs;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_status u_spi_rx_status (
    .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rxb), .rx_valid_i(valid),
    .byte_partial_i(partial), .cs_n_i(cs_n), .cfg_thresh_i(thresh),
    .cfg_flush_i(flush), .cfg_tim_i(tim), .cfg_dma_i(dma), .cfg_cont_i(cont),
    .cfg_master_i(master), .cfg_cs_irq_en_i(csen), .sta_rd_i(sta_rd),
    .fifo_rd_i(fifo_rd), .sta_o(sta), .rx_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_sta();
    logic [15:0] s;
    s = '0;
    s[14] = m_csr; s[13] = m_csf; s[12] = m_cse;
    s[11] = (m_cnt > int'(thresh));
    s[10:8] = 3'(m_cnt);
    s[7] = m_ovf; s[6] = m_rx;
    return s;
  endfunction

  function automatic logic exp_irq();
    return m_csr | m_csf | m_cse | m_rx | (m_ovf & ~flush);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_ovf = 0; m_rx = 0; m_cse = 0; m_csf = 0; m_csr = 0; m_cs = 1;
    for (int i = 0; i < 4; i++) m_q[i] = '0;
  endtask

  task automatic model_update();
    logic pop, push, ovfe, rxe, fe, re, ee, een;
    pop  = fifo_rd && m_cnt > 0 && !flush;
    push = valid && !flush && (m_cnt < 4 || pop);
    ovfe = valid && !flush && m_cnt == 4 && !pop;
    if (flush) m_cnt = 0;
    else begin
      if (pop) begin
        for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
        m_cnt--;
      end
      if (push) begin
        m_q[m_cnt] = rxb;
        m_cnt++;
      end
    end
    rxe = push && !tim && !dma && (m_cnt == int'(thresh) + 1);
    een = master && cont && csen;
    fe  = een && m_cs && !cs_n;
    re  = een && !m_cs && cs_n;
    ee  = !m_cs && cs_n && partial;
    m_ovf = ovfe | (m_ovf & ~sta_rd);
    m_rx  = rxe  | (m_rx  & ~sta_rd);
    m_cse = ee   | (m_cse & ~sta_rd);
    m_csf = fe   | (m_csf & ~sta_rd);
    m_csr = re   | (m_csr & ~sta_rd);
    m_cs  = cs_n;
  endtask

  // compare outputs against model, then advance one clock
  task automatic step();
    logic [15:0] e;
    #1;
    e = exp_sta();
    chk("R1 level", 16'(sta[10:8]), 16'(e[10:8]));
    chk("R1 data", 16'(rdata), 16'(m_cnt > 0 ? m_q[0] : 8'h00));
    chk("R2 ovf", 16'(sta[7]), 16'(e[7]));
    chk("R7 rx", 16'(sta[6]), 16'(e[6]));
    chk("R5 cserr", 16'(sta[12]), 16'(e[12]));
    chk("R4 csedge", 16'(sta[14:13]), 16'(e[14:13]));
    chk("R6 excess", 16'(sta[11]), 16'(e[11]));
    chk("R8 rsvd", 16'(sta[15]), 16'h0);
    chk("R9 irq", 16'(irq), 16'(exp_irq()));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    valid = 0; fifo_rd = 0; sta_rd = 0;
  endtask

  task automatic push_byte(logic [7:0] b);
    idle(); valid = 1; rxb = b; step(); idle();
  endtask

  task automatic read_sta();
    idle(); sta_rd = 1; step(); idle();
  endtask

  task automatic set_cs(logic v, logic part);
    idle(); cs_n = v; partial = part; step(); partial = 0;
  endtask

  initial begin
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset sta", sta, 16'h0000);
    chk("R8 reset irq", 16'(irq), 16'h0);
    rst_n = 1;
    @(negedge clk);

    // R7 / R1: threshold 2 -> rx flag on the 3rd byte
    thresh = 2'd2;
    push_byte(8'hA1); push_byte(8'hB2);
    #1 chk("R7 not yet", 16'(sta[6]), 16'h0);
    push_byte(8'hC3);
    #1 chk("R7 rx set", 16'(sta[6]), 16'h1);
    chk("R6 excess 3>2", 16'(sta[11]), 16'h1);
    push_byte(8'hD4);
    // R2: fifth byte overflows and is dropped
    push_byte(8'hE5);
    #1 chk("R2 ovf set", 16'(sta[7]), 16'h1);
    chk("R1 level full", 16'(sta[10:8]), 16'h4);
    chk("R1 head order", 16'(rdata), 16'h00A1);
    // R3: read clears rx and ovf
    read_sta();
    #1 chk("R3 cleared", 16'(sta[7:6]), 16'h0);
    // R11: push+pop on full -> no overflow
    idle(); valid = 1; rxb = 8'h5A; fifo_rd = 1; step(); idle();
    #1 chk("R11 full pushpop ovf", 16'(sta[7]), 16'h0);
    chk("R11 full pushpop level", 16'(sta[10:8]), 16'h4);
    chk("R1 order after pop", 16'(rdata), 16'h00B2);
    // overflow, then flush masks irq but keeps flag
    push_byte(8'h77);
    flush = 1; valid = 1; rxb = 8'h11; step(); idle();
    #1 chk("R9 ovf masked by flush", 16'(irq), 16'h0);
    chk("R9 ovf flag kept", 16'(sta[7]), 16'h1);
    chk("R10 flush empties", 16'(sta[10:8]), 16'h0);
    valid = 1; step(); idle();
    #1 chk("R10 push dropped", 16'(sta[10:8]), 16'h0);
    flush = 0; step();
    #1 chk("R9 ovf unmasked", 16'(irq), 16'h1);
    read_sta();
    // R11: pop on empty
    idle(); fifo_rd = 1; step(); idle();
    #1 chk("R11 empty level", 16'(sta[10:8]), 16'h0);
    chk("R11 empty data", 16'(rdata), 16'h0);

    // R4: edges ignored without continuous master with enable
    master = 1; cont = 0; csen = 1;
    set_cs(0, 0); set_cs(1, 0);
    #1 chk("R4 gated off", 16'(sta[14:13]), 16'h0);
    cont = 1;
    set_cs(0, 0);
    #1 chk("R4 fall", 16'(sta[13]), 16'h1);
    // R3: read coincident with rise: fall clears, rise kept
    idle(); sta_rd = 1; cs_n = 1; step(); idle();
    #1 chk("R3 old flag cleared", 16'(sta[13]), 16'h0);
    chk("R3 coincident kept", 16'(sta[14]), 16'h1);
    read_sta();
    // R5: release mid-byte
    master = 0;
    set_cs(0, 0); set_cs(1, 1);
    #1 chk("R5 cs error", 16'(sta[12]), 16'h1);
    chk("R9 irq from cserr", 16'(irq), 16'h1);
    read_sta();
    // R7: DMA blocks rx flag; R3: rx event on read cycle kept
    thresh = 0; dma = 1;
    push_byte(8'h01);
    #1 chk("R7 dma blocks", 16'(sta[6]), 16'h0);
    dma = 0; idle(); fifo_rd = 1; step();
    idle(); valid = 1; rxb = 8'h02; sta_rd = 1; step(); idle();
    #1 chk("R3 rx coincident kept", 16'(sta[6]), 16'h1);
    // R6: live threshold change
    thresh = 2'd1;
    #1 chk("R6 1>1 false", 16'(sta[11]), 16'h0);
    thresh = 2'd0;
    #1 chk("R6 1>0 true", 16'(sta[11]), 16'h1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      valid   = ($urandom_range(99) < 50);
      rxb     = 8'($urandom);
      fifo_rd = ($urandom_range(99) < 35);
      sta_rd  = ($urandom_range(99) < 15);
      flush   = ($urandom_range(99) < 4);
      partial = ($urandom_range(99) < 40);
      if ($urandom_range(99) < 12) cs_n = ~cs_n;
      if ($urandom_range(99) < 3) begin
        thresh = 2'($urandom); tim = 1'($urandom); dma = ($urandom_range(3) == 0);
        cont = 1'($urandom); master = 1'($urandom); csen = ($urandom_range(3) != 0);
      end
      step();
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    done = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule